// File: doc/BRIEF.md
# Clock-Control Configuration Receiver over Two-Wire Serial

This block is a receive-only slave on a two-wire serial bus. It loads a small bank of clock-control registers that a clock generator uses to gate its outputs. The host sends one kind of transaction: a block write. That is a START, the device address with the write direction bit, a command byte, a count byte, the data bytes, and a STOP. The slave acknowledges every byte of a transaction addressed to it. It throws away the command and count bytes, then stores the data bytes in register 0, register 1, register 2 and so on, in that order. The host may end the transfer after any whole byte.

Both bus lines are sampled in the system clock domain. Each line is synchronized and then debounced before any START, STOP or clock edge is decoded. The slave acknowledges by driving SDA low through an open-drain enable output. It has no read path, no indexed access and no clock stretching.

Register 0 holds the spread-spectrum enable and three auxiliary clock enables. Register 1 holds eight memory clock enables. Register 2 holds seven bus clock enables. The parallel outputs drive the clock generator's gating logic.

Top module: `clkcfg_twowire_slave`

## Requirements
- R1: After reset the spread-spectrum enable is 0 and every clock enable output is 1.
- R2: A byte following START is accepted only when it equals 0xD2 (address 0x69, direction bit 0). Any other value, including the read form 0xD3, is not acknowledged, and the rest of that transaction changes no register and draws no acknowledge.
- R3: In an accepted transaction, the second and third bytes (command and count) are acknowledged and never written to any register, whatever their values.
- R4: The data bytes after the count byte are written to register 0, register 1 and register 2 in arrival order. Each byte is assembled MSB first, bit 7 on the first SCL rise.
- R5: The register 0 fields are: bit 3 drives `ss_en_o`, bit 2 drives `dot_en_o`, bit 1 drives `usb_en_o` and bit 0 drives `cpudbg_en_o`. Register 1 bit k drives `sdram_en_o[k]`. Register 2 bit k drives `pci_en_o[k]` for k = 7..1. The value 1 enables.
- R6: Data bytes beyond the third are acknowledged but leave every output unchanged.
- R7: A STOP after any complete data byte keeps the bytes already received and leaves the later registers unchanged.
- R8: A STOP or repeated START inside a byte discards the partial byte. A repeated START begins a fresh address phase.
- R9: A pulse on SCL or SDA shorter than `FILT_LEN` system clock cycles has no effect on decoding.
- R10: The slave pulls SDA low from the SCL fall after the eighth bit of an accepted byte until the next SCL fall. It leaves SDA released at all other times, including after STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | When 1, drive SDA low (open drain) |
| ss_en_o | output | 1 | Spread-spectrum enable |
| dot_en_o | output | 1 | Dot clock enable |
| usb_en_o | output | 1 | USB clock enable |
| cpudbg_en_o | output | 1 | Debug-port CPU clock enable |
| sdram_en_o | output | 8 | Memory clock enables 7..0 |
| pci_en_o | output | 7 | Bus clock enables 7..1 |

## Verification
A change on either line reaches the decoder after the two-flop synchronizer plus `FILT_LEN` filter cycles, which is about six system clocks. The acknowledge drive therefore appears about seven clocks after SCL falls, and a register updates two clocks after the filtered eighth SCL rise. The bench holds every bus phase for ten system clocks. It samples the acknowledge in the middle of the ninth SCL high phase and reads the register outputs only after the STOP has settled, so each result is sampled well after its due cycle. Glitches of two cycles stay below the filter length.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned NUM_REGS = 3;
  localparam logic [6:0]  DEV_ADDR = 7'h69;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA, ST_SKIP
  } bus_state_e;

  function automatic logic [7:0] reg_init(int unsigned idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      2:       return 8'hFE;
      default: return 8'h00;
    endcase
  endfunction

  // implemented bits per register; others read as zero
  function automatic logic [7:0] reg_mask(int unsigned idx);
    case (idx)
      0:       return 8'h0F;
      1:       return 8'hFF;
      2:       return 8'hFE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_pin_filter.sv
module clkcfg_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  // output follows only after FILT_LEN consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o <= 1'b1;
      cnt_q <= '0;
    end else if (pin_s == pin_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      pin_o <= pin_s;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_FILT_AGREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o != $past(pin_o)) |-> ($past(pin_s) == pin_o)); // R9
endmodule

// File: rtl/clkcfg_bus_engine.sv
module clkcfg_bus_engine
  import clkcfg_pkg::*;
#(
  parameter int unsigned NREG  = NUM_REGS,
  parameter int unsigned IDX_W = $clog2(NREG + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_f_i,
  input  logic             sda_f_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  bus_state_e       state_q;
  logic             scl_q, sda_q;
  logic             scl_rise, scl_fall, start_evt, stop_evt;
  logic [2:0]       bit_cnt_q;
  logic [6:0]       shreg_q;
  logic [7:0]       nb;
  logic             full_q, take_q, ack_q;
  logic [IDX_W-1:0] idx_q;
  logic             rx_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise  = scl_f_i & ~scl_q;
  assign scl_fall  = ~scl_f_i & scl_q;
  assign start_evt = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_evt  = scl_f_i & scl_q & ~sda_q & sda_f_i;
  assign nb        = {shreg_q, sda_f_i};
  assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                     (state_q == ST_CNT)  || (state_q == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      full_q    <= 1'b0;
      take_q    <= 1'b0;
      ack_q     <= 1'b0;
      sda_oe_o  <= 1'b0;
      idx_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_evt || stop_evt) begin
        state_q   <= start_evt ? ST_ADDR : ST_IDLE;
        bit_cnt_q <= '0;
        full_q    <= 1'b0;
        take_q    <= 1'b0;
        ack_q     <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else begin
        if (scl_rise && !ack_q && !full_q && rx_state) begin
          shreg_q   <= nb[6:0];
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            full_q <= 1'b1;
            take_q <= 1'b1;
            case (state_q)
              ST_ADDR: begin
                if (nb == {DEV_ADDR, 1'b0}) state_q <= ST_CMD;
                else begin
                  state_q <= ST_SKIP;
                  take_q  <= 1'b0;
                end
              end
              ST_CMD: state_q <= ST_CNT;
              ST_CNT: begin
                state_q <= ST_DATA;
                idx_q   <= '0;
              end
              ST_DATA: begin
                if (idx_q < IDX_W'(NREG)) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= idx_q;
                  wr_data_o <= nb;
                  idx_q     <= idx_q + IDX_W'(1);
                end
              end
              default: take_q <= 1'b0;
            endcase
          end
        end
        if (scl_fall) begin
          if (full_q) begin
            full_q <= 1'b0;
            if (take_q) begin
              sda_oe_o <= 1'b1;
              ack_q    <= 1'b1;
            end
          end else if (ack_q) begin
            sda_oe_o <= 1'b0;
            ack_q    <= 1'b0;
          end
        end
      end
    end
  end

  AST_START_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_oe_o); // R8
  AST_ACK_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f_i); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o); // R10
  AST_WR_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (state_q == ST_DATA)); // R3
endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int unsigned NREG  = NUM_REGS,
  parameter int unsigned IDX_W = $clog2(NREG + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [7:0]               wr_data_i,
  output logic [NREG-1:0][7:0]     regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] MASK = reg_mask(g);
    localparam logic [7:0] INIT = reg_init(g) & MASK;
    logic [7:0] r_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  r_q <= INIT;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    r_q <= wr_data_i & MASK;
    end

    assign regs_o[g] = r_q;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o)); // R7
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i < IDX_W'(NREG))); // R6
endmodule

// File: rtl/clkcfg_twowire_slave.sv
module clkcfg_twowire_slave
  import clkcfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       ss_en_o,
  output logic       dot_en_o,
  output logic       usb_en_o,
  output logic       cpudbg_en_o,
  output logic [7:0] sdram_en_o,
  output logic [7:1] pci_en_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS + 1);

  logic                     scl_f, sda_f;
  logic                     wr_en;
  logic [IDX_W-1:0]         wr_idx;
  logic [7:0]               wr_data;
  logic [NUM_REGS-1:0][7:0] regs;
  logic                     unused_bits;

  clkcfg_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_scl_filt (
    .clk_i, .rst_ni, .pin_i(scl_i), .pin_o(scl_f)
  );

  clkcfg_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_sda_filt (
    .clk_i, .rst_ni, .pin_i(sda_i), .pin_o(sda_f)
  );

  clkcfg_bus_engine #(.NREG(NUM_REGS), .IDX_W(IDX_W)) i_engine (
    .clk_i, .rst_ni,
    .scl_f_i(scl_f), .sda_f_i(sda_f),
    .sda_oe_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  clkcfg_reg_bank #(.NREG(NUM_REGS), .IDX_W(IDX_W)) i_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .regs_o(regs)
  );

  assign ss_en_o     = regs[0][3];
  assign dot_en_o    = regs[0][2];
  assign usb_en_o    = regs[0][1];
  assign cpudbg_en_o = regs[0][0];
  assign sdram_en_o  = regs[1];
  assign pci_en_o    = regs[2][7:1];
  assign unused_bits = ^{regs[0][7:4], regs[2][0]};
endmodule

// File: tb/test_clkcfg_twowire_slave.sv
module test_clkcfg_twowire_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_line, sda_oe, ss_en, dot_en, usb_en, cpu_en;
  logic [7:0] sdram_en;
  logic [7:1] pci_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] e0 = 8'h07, e1 = 8'hFF, e2 = 8'hFE;
  logic [7:0] dbuf [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  clkcfg_twowire_slave i_clkcfg_twowire_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .ss_en_o(ss_en), .dot_en_o(dot_en), .usb_en_o(usb_en),
    .cpudbg_en_o(cpu_en), .sdram_en_o(sdram_en), .pci_en_o(pci_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic qwait(); repeat (Q) @(negedge clk); endtask

  task automatic send_start();
    sda_h = 1'b1; qwait(); scl_h = 1'b1; qwait(); sda_h = 1'b0; qwait(); scl_h = 1'b0; qwait();
  endtask

  task automatic send_stop();
    sda_h = 1'b0; qwait(); scl_h = 1'b1; qwait(); sda_h = 1'b1; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit glitch);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_h = b[i]; qwait(); scl_h = 1'b1; qwait();
      if (glitch) begin
        sda_h = ~b[i]; repeat (2) @(negedge clk); sda_h = b[i];
      end
      qwait(); scl_h = 1'b0; qwait();
      if (glitch) begin
        scl_h = 1'b1; repeat (2) @(negedge clk); scl_h = 1'b0; qwait();
      end
    end
  endtask

  task automatic read_ack(output logic a);
    sda_h = 1'b1; qwait(); scl_h = 1'b1; qwait(); a = ~sda_line; qwait(); scl_h = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    send_bits(b, 8, 1'b0); read_ack(a);
  endtask

  task automatic put(input int i, input logic [7:0] b);
    if (i == 0) e0 = b; else if (i == 1) e1 = b; else if (i == 2) e2 = b;
  endtask

  task automatic check_regs(input string req);
    chk({ss_en, dot_en, usb_en, cpu_en, sdram_en, pci_en} == {e0[3:0], e1, e2[7:1]},
        req, "register outputs", {13'd0, ss_en, dot_en, usb_en, cpu_en, sdram_en, pci_en},
        {13'd0, e0[3:0], e1, e2[7:1]});
  endtask

  task automatic txn(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                     input int n, input string req);
    logic a;
    bit hit;
    hit = (addr == 8'hD2);
    send_start();
    send_byte(addr, a); chk(a == hit, "R2", "address ack", a, hit);
    send_byte(cmd, a);  chk(a == hit, "R3", "command ack", a, hit);
    send_byte(cnt, a);  chk(a == hit, "R3", "count ack", a, hit);
    for (int i = 0; i < n; i++) begin
      send_byte(dbuf[i], a);
      chk(a == hit, (i >= 3) ? "R6" : "R4", "data ack", a, hit);
      if (hit) put(i, dbuf[i]);
    end
    send_stop();
    check_regs(req);
    chk(sda_oe == 1'b0, "R10", "SDA released after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_regs("R1");
    chk(ss_en == 1'b0, "R1", "spread off", ss_en, 0);
    chk(sda_oe == 1'b0, "R10", "idle release", sda_oe, 0);

    // R4 ordered write, R3 nonzero command ignored
    dbuf[0] = 8'hA5; dbuf[1] = 8'h3C; dbuf[2] = 8'h96;
    txn(8'hD2, 8'h5F, 8'h03, 3, "R4");

    // R5 field positions
    dbuf[0] = 8'h08; dbuf[1] = 8'h01; dbuf[2] = 8'h80;
    txn(8'hD2, 8'h00, 8'h03, 3, "R5");
    chk(ss_en == 1'b1 && {dot_en, usb_en, cpu_en} == 3'b000, "R5", "reg0 bit3 spread", {ss_en, dot_en, usb_en, cpu_en}, 4'b1000);
    chk(sdram_en == 8'h01, "R5", "reg1 sdram bit0", sdram_en, 8'h01);
    chk(pci_en == 7'b1000000, "R5", "reg2 pci7", pci_en, 7'b1000000);
    dbuf[0] = 8'h04; txn(8'hD2, 8'h00, 8'h01, 1, "R5");
    chk({ss_en, dot_en, usb_en, cpu_en} == 4'b0100, "R5", "reg0 bit2 dot", {ss_en, dot_en, usb_en, cpu_en}, 4'b0100);

    // R2 read form and foreign address
    dbuf[0] = 8'h0F; dbuf[1] = 8'h00; dbuf[2] = 8'h00;
    txn(8'hD3, 8'h00, 8'h03, 3, "R2");
    txn(8'hA4, 8'h00, 8'h03, 3, "R2");

    // R6 bytes beyond the third
    dbuf[0] = 8'h0A; dbuf[1] = 8'h5A; dbuf[2] = 8'hA4;
    for (int i = 3; i < 8; i++) dbuf[i] = 8'hFF ^ 8'(i);
    txn(8'hD2, 8'h00, 8'h08, 8, "R6");

    // R7 stop after first data byte
    dbuf[0] = 8'h03; txn(8'hD2, 8'h00, 8'h05, 1, "R7");
    chk(sdram_en == 8'h5A, "R7", "reg1 untouched", sdram_en, 8'h5A);

    // R8 stop inside a byte
    send_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
    send_byte(8'h0C, a); put(0, 8'h0C);
    send_bits(8'h33, 4, 1'b0); send_stop();
    check_regs("R8");

    // R8 repeated start inside a byte
    send_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h02, a);
    send_bits(8'hC3, 3, 1'b0);
    send_start(); send_byte(8'hD2, a);
    chk(a == 1'b1, "R8", "address ack after repeated start", a, 1);
    send_byte(8'h00, a); send_byte(8'h01, a); send_byte(8'h0E, a); put(0, 8'h0E);
    send_stop();
    check_regs("R8");

    // R9 short glitches on both lines
    send_start(); send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h02, a);
    send_bits(8'h6B, 8, 1'b1); read_ack(a);
    chk(a == 1'b1, "R9", "ack after glitched byte", a, 1);
    put(0, 8'h6B);
    send_byte(8'h94, a); put(1, 8'h94);
    send_stop();
    check_regs("R9");

    // random traffic
    for (int t = 0; t < 14; t++) begin
      logic [7:0] ad;
      int n;
      ad = ($urandom % 4 == 0) ? 8'($urandom) : 8'hD2;
      n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      txn(ad, 8'($urandom), 8'(n), n, "R4");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule